// File: doc/BRIEF.md
# Message DMA Transfer Engine

This engine stores an incoming message from the router's processor port into a word-addressed memory, so the CPU does not copy the words itself. The CPU sets up a transfer through a four-entry register window. It writes the number of words, then the first memory address, then a start command. While the engine moves the words the CPU can do other work. The engine writes one memory word for each word it accepts from the port. After each word it adds one to the address and subtracts one from the count. When the count runs out it raises an interrupt. The interrupt stays high until the CPU writes an acknowledge.

The controller has three states. In IDLE, a start command moves it to XFER when the count is non-zero, or straight to DONE when the count is zero. In XFER, accepting the word that brings the count down to zero moves it to DONE. In DONE the interrupt is high, and an acknowledge moves it back to IDLE. Register select codes: 0 = word count, 1 = memory address, 2 = control/status (a write is a start command, the write data is ignored), 3 = acknowledge (write only, reads as zero). The status word reads bit 0 = busy (XFER) and bit 1 = done (DONE), with all other bits zero.

Top module: `msg_dma`

## Requirements
- R1: While reset is active and just after it, irq, pv_ready and mem_we are 0, and the count, address and status reads all return 0.
- R2: In IDLE, a write with cpu_sel=0 loads the word count from cpu_wdata, and a read with cpu_sel=0 returns the current count.
- R3: In IDLE, a write with cpu_sel=1 loads the memory address from cpu_wdata, and a read with cpu_sel=1 returns the current address.
- R4: A write with cpu_sel=2 in IDLE with a non-zero count enters XFER on the next cycle. There, pv_ready is 1 and the status read is 1.
- R5: In XFER, every cycle with pv_valid high is one memory write (mem_we=1, mem_addr = current address, mem_wdata = pv_data). After it the address is one higher (modulo 2^AW) and the count is one lower. Cycles with pv_valid low write nothing and leave both registers unchanged.
- R6: The cycle after the word that takes the count to zero, irq is 1, pv_ready is 0 and the status read is 2.
- R7: irq stays at 1 in DONE until a write with cpu_sel=3. The cycle after that write, irq is 0 and the status read is 0.
- R8: In XFER, writes to the count or address registers are ignored.
- R9: A start with a count of zero sets irq on the next cycle and performs no memory write.
- R10: A start outside IDLE and an acknowledge outside DONE leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_sel | input | 2 | Register select (0 count, 1 address, 2 control/status, 3 acknowledge) |
| cpu_wdata | input | DW | Register write data |
| cpu_rdata | output | DW | Register read data for cpu_sel (combinational) |
| irq | output | 1 | Completion interrupt |
| pv_valid | input | 1 | Processor port offers a word |
| pv_data | input | DW | Word from the processor port |
| pv_ready | output | 1 | Engine accepts words (XFER) |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |

## Verification
A zero-length start is tested to show that it interrupts at once without touching memory. A design that goes into XFER anyway would either never finish or wrap the count and write 2^CW words. A transfer that starts near the top of the address space shows whether the address wraps cleanly, and one with gaps in pv_valid shows whether idle cycles write nothing and leave the registers alone. Register writes, starts and acknowledges issued in the wrong state are tested to show they are ignored. A design that honoured them would move the buffer in the middle of a message, restart, or drop the interrupt before the CPU has seen it.

// File: rtl/msg_dma_pkg.sv
package msg_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } dma_state_t;

    localparam logic [1:0] SEL_COUNT = 2'd0;
    localparam logic [1:0] SEL_ADDR  = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;
    localparam logic [1:0] SEL_ACK   = 2'd3;

endpackage

// File: rtl/dma_regs.sv
module dma_regs #(
    parameter int AW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_wr,
    input  logic          addr_wr,
    input  logic [CW-1:0] cnt_in,
    input  logic [AW-1:0] addr_in,
    input  logic          busy,
    input  logic          beat,
    output logic [CW-1:0] cnt_q,
    output logic [AW-1:0] addr_q,
    output logic          cnt_zero,
    output logic          last_beat
);

    logic load_cnt;
    logic load_addr;

    // Register loads are refused while a transfer is running
    assign load_cnt  = cnt_wr  && !busy;
    assign load_addr = addr_wr && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_cnt) begin
            cnt_q <= cnt_in;
        end else if (beat) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_addr) begin
            addr_q <= addr_in;
        end else if (beat) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign cnt_zero  = (cnt_q == '0);
    assign last_beat = (cnt_q == CW'(1));

    // R5: one step per accepted word
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beat |=> cnt_q == CW'($past(cnt_q) - 1'b1));

    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beat |=> addr_q == AW'($past(addr_q) + 1'b1));

    // R8: nothing moves while busy without a word
    p_busy_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !beat) |=> ($stable(cnt_q) && $stable(addr_q)));

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
    import msg_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic ack_req,
    input  logic cnt_zero,
    input  logic last_beat,
    input  logic beat,
    output logic busy,
    output logic done
);

    dma_state_t state_q;
    dma_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_req) state_d = cnt_zero ? ST_DONE : ST_XFER;
            ST_XFER: if (beat && last_beat) state_d = ST_DONE;
            ST_DONE: if (ack_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_XFER: busy = 1'b1;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    p_last_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && beat && last_beat) |=> (done && !busy));

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ack_req) |=> done);

    p_ack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ack_req) |=> (!done && !busy));

    p_zero_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start_req && cnt_zero) |=> done);

    p_stray_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_req && !beat) |=> busy);

endmodule

// File: rtl/msg_dma.sv
module msg_dma
    import msg_dma_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_we,
    input  logic [1:0]    cpu_sel,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          irq,
    input  logic          pv_valid,
    input  logic [DW-1:0] pv_data,
    output logic          pv_ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);

    logic          start_req;
    logic          ack_req;
    logic          cnt_wr;
    logic          addr_wr;
    logic          busy;
    logic          done;
    logic          beat;
    logic          cnt_zero;
    logic          last_beat;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] addr_q;
    logic          wdata_unused;

    assign cnt_wr    = cpu_we && (cpu_sel == SEL_COUNT);
    assign addr_wr   = cpu_we && (cpu_sel == SEL_ADDR);
    assign start_req = cpu_we && (cpu_sel == SEL_CTRL);
    assign ack_req   = cpu_we && (cpu_sel == SEL_ACK);
    assign wdata_unused = ^cpu_wdata;

    assign beat = busy && pv_valid;

    dma_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .ack_req   (ack_req),
        .cnt_zero  (cnt_zero),
        .last_beat (last_beat),
        .beat      (beat),
        .busy      (busy),
        .done      (done)
    );

    dma_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_wr    (cnt_wr),
        .addr_wr   (addr_wr),
        .cnt_in    (cpu_wdata[CW-1:0]),
        .addr_in   (cpu_wdata[AW-1:0]),
        .busy      (busy),
        .beat      (beat),
        .cnt_q     (cnt_q),
        .addr_q    (addr_q),
        .cnt_zero  (cnt_zero),
        .last_beat (last_beat)
    );

    assign pv_ready  = busy;
    assign mem_we    = beat;
    assign mem_addr  = addr_q;
    assign mem_wdata = pv_data;
    assign irq       = done;

    always_comb begin
        cpu_rdata = '0;
        unique case (cpu_sel)
            SEL_COUNT: cpu_rdata[CW-1:0] = cnt_q;
            SEL_ADDR:  cpu_rdata[AW-1:0] = addr_q;
            SEL_CTRL:  cpu_rdata[1:0]    = {done, busy};
            default:   cpu_rdata = '0;
        endcase
    end

    // R9: a zero-length start never reaches memory
    p_zero_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pv_ready && !irq && start_req && cpu_rdata_cnt_is_zero()) |=> !mem_we);

    function automatic logic cpu_rdata_cnt_is_zero();
        return cnt_zero;
    endfunction

endmodule

// File: tb/sim_msg_dma.sv
`timescale 1ns/1ps
module sim_msg_dma;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam int CW = 8;

    typedef struct packed {
        logic [7:0]  cnt;
        logic [7:0]  base;
        logic [15:0] seed;
        logic        gap;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{8'd1, 8'h10, 16'h1000, 1'b0},
        '{8'd4, 8'h20, 16'hA5A0, 1'b1},
        '{8'd6, 8'hFD, 16'h3300, 1'b0},
        '{8'd3, 8'h80, 16'hBEE0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpu_we;
    logic [1:0]    cpu_sel;
    logic [DW-1:0] cpu_wdata;
    logic [DW-1:0] cpu_rdata;
    logic          irq;
    logic          pv_valid;
    logic [DW-1:0] pv_data;
    logic          pv_ready;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    logic [DW-1:0] mem [0:(1<<AW)-1];
    int nwr = 0;
    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    msg_dma #(.DW(DW), .AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
        .pv_valid(pv_valid), .pv_data(pv_data), .pv_ready(pv_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            nwr <= nwr + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cpu_wr(input logic [1:0] sel, input logic [DW-1:0] data);
        cpu_sel   = sel;
        cpu_wdata = data;
        cpu_we    = 1'b1;
        tick();
        cpu_we    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [DW-1:0] val);
        cpu_sel = sel;
        #1;
        val = cpu_rdata;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #(8 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL R4 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        int w0;
        rst_n = 1'b0; cpu_we = 1'b0; cpu_sel = 2'd0; cpu_wdata = '0;
        pv_valid = 1'b0; pv_data = '0;
        tick(); tick(); tick();
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 pv_ready", pv_ready, 0);
        chk("R1 mem_we", mem_we, 0);
        rst_n = 1'b1;
        tick();
        rd(2'd0, v); chk("R1 count", v, 0);
        rd(2'd1, v); chk("R1 addr", v, 0);
        rd(2'd2, v); chk("R1 status", v, 0);

        // Vector table: R2..R7
        for (int k = 0; k < 4; k++) begin
            cpu_wr(2'd0, {8'd0, VEC[k].cnt});
            cpu_wr(2'd1, {8'd0, VEC[k].base});
            rd(2'd0, v); chk("R2 count readback", v, {8'd0, VEC[k].cnt});
            rd(2'd1, v); chk("R3 addr readback", v, {8'd0, VEC[k].base});
            w0 = nwr;
            cpu_wr(2'd2, '0);
            rd(2'd2, v); chk("R4 status busy", v, 1);
            chk("R4 pv_ready", pv_ready, 1);
            for (int i = 0; i < int'(VEC[k].cnt); i++) begin
                if (VEC[k].gap) begin
                    pv_valid = 1'b0;
                    #1;
                    chk("R5 no write on gap", mem_we, 0);
                    tick();
                    rd(2'd0, v); chk("R5 count held on gap", v, VEC[k].cnt - 8'(i));
                end
                pv_valid = 1'b1;
                pv_data  = VEC[k].seed + 16'(i);
                #1;
                chk("R5 mem_we", mem_we, 1);
                chk("R5 mem_addr", mem_addr, 8'(VEC[k].base + 8'(i)));
                tick();
            end
            pv_valid = 1'b0;
            chk("R6 irq", irq, 1);
            chk("R6 pv_ready", pv_ready, 0);
            rd(2'd2, v); chk("R6 status done", v, 2);
            chk("R5 write count", nwr - w0, VEC[k].cnt);
            for (int i = 0; i < int'(VEC[k].cnt); i++) begin
                chk("R5 memory word", mem[8'(VEC[k].base + 8'(i))], VEC[k].seed + 16'(i));
            end
            rd(2'd0, v); chk("R5 final count", v, 0);
            rd(2'd1, v); chk("R5 final addr wraps", v, {8'd0, 8'(VEC[k].base + VEC[k].cnt)});
            cpu_wr(2'd3, '0);
            chk("R7 irq cleared", irq, 0);
            rd(2'd2, v); chk("R7 status idle", v, 0);
        end

        // R9 zero-length start, R7 hold, R10 start in DONE
        cpu_wr(2'd0, 16'd0);
        cpu_wr(2'd1, 16'h30);
        w0 = nwr;
        pv_valid = 1'b1; pv_data = 16'h7777;
        cpu_wr(2'd2, '0);
        chk("R9 irq immediate", irq, 1);
        chk("R9 no pv_ready", pv_ready, 0);
        chk("R9 no mem_we", mem_we, 0);
        for (int i = 0; i < 5; i++) tick();
        chk("R9 no memory write", nwr - w0, 0);
        chk("R7 irq held", irq, 1);
        pv_valid = 1'b0;
        cpu_wr(2'd2, '0);
        rd(2'd2, v); chk("R10 start in DONE ignored", v, 2);
        cpu_wr(2'd3, '0);
        chk("R7 ack clears", irq, 0);

        // R8 busy lockout, R10 stray ack/start in XFER
        cpu_wr(2'd0, 16'd3);
        cpu_wr(2'd1, 16'h40);
        cpu_wr(2'd2, '0);
        cpu_wr(2'd0, 16'd9);
        cpu_wr(2'd1, 16'h10);
        rd(2'd0, v); chk("R8 count locked", v, 3);
        rd(2'd1, v); chk("R8 addr locked", v, 16'h40);
        cpu_wr(2'd3, '0);
        rd(2'd2, v); chk("R10 ack in XFER ignored", v, 1);
        cpu_wr(2'd2, '0);
        rd(2'd2, v); chk("R10 start in XFER ignored", v, 1);
        rd(2'd0, v); chk("R10 count after restart", v, 3);
        w0 = nwr;
        for (int i = 0; i < 3; i++) begin
            pv_valid = 1'b1;
            pv_data  = 16'hC000 + 16'(i);
            tick();
        end
        pv_valid = 1'b0;
        chk("R8 irq after lockout run", irq, 1);
        chk("R8 writes", nwr - w0, 3);
        for (int i = 0; i < 3; i++) begin
            chk("R8 data at original addr", mem[8'h40 + 8'(i)], 16'hC000 + 16'(i));
        end
        cpu_wr(2'd3, '0);
        chk("R7 final ack", irq, 0);

        summary();
        $finish;
    end
endmodule